// File: doc/BRIEF.md
# Cache-Line AXI Read Requester

This block converts one read request at a time into a single AXI4 read burst. A request is one of three kinds: a single-word uncached load, an instruction-cache line refill, or a data-cache line refill. The kind alone sets the burst length. A load is one beat. A refill brings in a whole line of the matching cache. The memory attributes and the burst type are the same for every request.

The returned beats are written into a line buffer in arrival order, starting at word 0. When the transaction ends, the block presents the buffer for one cycle together with the request kind and two error flags. The first flag is sticky and records a failing read response on any beat. The second records a last-beat marker that came on the wrong beat or did not come at all. The read-data user sideband is accepted but plays no part in the result.

The block allows only one transaction in flight. The requester sees this as `req_ready`, which stays low from the moment a request is accepted until the response pulse has been given.

Top module: `line_fetch_axi`

## Requirements
- R1: After reset, `req_ready` is 1 and `ar_valid`, `r_ready` and `rsp_valid` are 0.
- R2: `ar_len` is 0 for kind 0 (word load) and for kind 3, which is treated as a word load. It is IC_LINE_W/DATA_W-1 for kind 1 (instruction line) and DC_LINE_W/DATA_W-1 for kind 2 (data line). `rsp_kind` returns the kind that was accepted.
- R3: Every address request carries `ar_cache` = 4'b0010 (normal, non-cacheable, non-bufferable), `ar_burst` = 2'b01 (incrementing) and `ar_id` = 0.
- R4: For a line kind, `ar_size` is log2(DATA_W/8). For a word load it is `req_size`, and any value above log2(DATA_W/8) is reduced to that maximum.
- R5: For a line kind, `ar_addr` is the request address with the low bits below the line size (in bytes) cleared. For a word load it is the request address unchanged.
- R6: `ar_valid` rises in the cycle after acceptance. It stays high with its fields stable until `ar_ready`. `r_ready` is high only from the cycle after the address handshake until the final beat is taken.
- R7: Beat k of the burst is placed at `rsp_line[k*DATA_W +: DATA_W]`. Words that were not written in the current transaction read as zero.
- R8: The transaction ends on the first beat that either carries `r_last` or has index `ar_len`. `rsp_err_proto` is 1 if `r_last` arrived on any beat whose index is not `ar_len`, or was absent on the beat whose index is `ar_len`.
- R9: `rsp_err_resp` is 1 if any beat of the transaction had `r_resp` other than 2'b00. The flag is cleared when the next request is accepted.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the final beat handshake. `req_ready` is 0 from acceptance through that pulse and returns to 1 in the following cycle.
- R11: `r_user` has no effect on `rsp_line` or on either error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 0 word, 1 instruction line, 2 data line, 3 treated as word |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 3 | log2 of bytes for a word load |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_id | output | ID_W | Transaction ID, always 0 |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, always incrementing |
| ar_cache | output | 4 | Memory attributes, always 4'b0010 |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | DATA_W | Read data beat |
| r_resp | input | 2 | Beat response |
| r_last | input | 1 | Last-beat marker |
| r_user | input | USER_W | User sideband, ignored |
| rsp_valid | output | 1 | Completion pulse |
| rsp_kind | output | 2 | Kind of the completed request |
| rsp_line | output | MAX_LINE_W | Collected line, word 0 in the low bits |
| rsp_err_resp | output | 1 | Some beat returned an error response |
| rsp_err_proto | output | 1 | Last-beat marker misplaced or missing |

## Verification
The assertions rely on a few properties of the inputs. A word-load address is aligned to `req_size`. The subordinate sends no read beat before the address handshake, and it sends no further beat once the block has closed the transaction. `r_user` carries known values. The stimulus respects all of this. Each transaction is driven through one task that raises `r_valid` only while `r_ready` is high and stops at exactly the number of beats the block will take, even in the early-marker and missing-marker cases. The wait states on the address and data channels vary between runs, and so does the sideband value.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
  typedef enum logic [1:0] {
    KIND_WORD  = 2'd0,
    KIND_ILINE = 2'd1,
    KIND_DLINE = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } fsm_e;

  localparam logic [3:0] ATTR_NORMAL_NC_NB = 4'b0010;
  localparam logic [1:0] BURST_INCR        = 2'b01;
endpackage

// File: rtl/lfa_burst_plan.sv
module lfa_burst_plan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int IC_LINE_W = 256,
  parameter int DC_LINE_W = 512
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [ADDR_W-1:0] plan_addr,
  output logic [7:0]        plan_len,
  output logic [2:0]        plan_size
);
  import lfa_pkg::*;

  localparam int BUS_BYTES = DATA_W / 8;
  localparam logic [2:0] FULL_SIZE = 3'($clog2(BUS_BYTES));
  localparam int IC_BEATS = IC_LINE_W / DATA_W;
  localparam int DC_BEATS = DC_LINE_W / DATA_W;
  localparam logic [ADDR_W-1:0] IC_KEEP = ~(ADDR_W'(IC_LINE_W / 8) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] DC_KEEP = ~(ADDR_W'(DC_LINE_W / 8) - ADDR_W'(1));

  always_comb begin
    case (kind)
      KIND_ILINE: begin
        plan_addr = addr & IC_KEEP;
        plan_len  = 8'(IC_BEATS - 1);
        plan_size = FULL_SIZE;
      end
      KIND_DLINE: begin
        plan_addr = addr & DC_KEEP;
        plan_len  = 8'(DC_BEATS - 1);
        plan_size = FULL_SIZE;
      end
      default: begin
        plan_addr = addr;
        plan_len  = 8'd0;
        plan_size = (size > FULL_SIZE) ? FULL_SIZE : size;
      end
    endcase
  end
endmodule

// File: rtl/lfa_beat_track.sv
module lfa_beat_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] len,
  input  logic       beat_fire,
  input  logic       beat_last,
  input  logic [1:0] beat_resp,
  output logic [7:0] beat_idx,
  output logic       final_beat,
  output logic       err_resp,
  output logic       err_proto
);
  logic [7:0] cnt_q;
  logic       at_end;

  assign at_end     = (cnt_q == len);
  assign final_beat = beat_fire && (beat_last || at_end);
  assign beat_idx   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q     <= 8'd0;
      err_resp  <= 1'b0;
      err_proto <= 1'b0;
    end else if (beat_fire) begin
      cnt_q <= final_beat ? 8'd0 : cnt_q + 8'd1;
      if (beat_resp != 2'b00) err_resp <= 1'b1;
      if (beat_last != at_end) err_proto <= 1'b1;
    end
  end

  // R8: the beat index never runs past the burst length
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len);

  // R9: an error flag, once set, holds until a new transaction starts
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    err_resp && !start |=> err_resp);
endmodule

// File: rtl/lfa_line_buf.sv
module lfa_line_buf #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [7:0]              wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [WORDS*DATA_W-1:0] line
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst || clear)
        word_q <= '0;
      else if (wr_en && wr_idx == 8'(w))
        word_q <= wr_data;
    end
    assign line[w*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/line_fetch_axi.sv
module line_fetch_axi #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int ID_W      = 4,
  parameter int USER_W    = 2,
  parameter int IC_LINE_W = 256,
  parameter int DC_LINE_W = 512,
  localparam int MAX_LINE_W = (IC_LINE_W > DC_LINE_W) ? IC_LINE_W : DC_LINE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_kind,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2:0]            req_size,
  output logic                  ar_valid,
  input  logic                  ar_ready,
  output logic [ID_W-1:0]       ar_id,
  output logic [ADDR_W-1:0]     ar_addr,
  output logic [7:0]            ar_len,
  output logic [2:0]            ar_size,
  output logic [1:0]            ar_burst,
  output logic [3:0]            ar_cache,
  input  logic                  r_valid,
  output logic                  r_ready,
  input  logic [DATA_W-1:0]     r_data,
  input  logic [1:0]            r_resp,
  input  logic                  r_last,
  input  logic [USER_W-1:0]     r_user,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_kind,
  output logic [MAX_LINE_W-1:0] rsp_line,
  output logic                  rsp_err_resp,
  output logic                  rsp_err_proto
);
  import lfa_pkg::*;

  localparam int WORDS = MAX_LINE_W / DATA_W;
  localparam logic [7:0] IC_LEN = 8'(IC_LINE_W / DATA_W - 1);
  localparam logic [7:0] DC_LEN = 8'(DC_LINE_W / DATA_W - 1);
  localparam logic [ADDR_W-1:0] IC_LOW = ADDR_W'(IC_LINE_W / 8 - 1);
  localparam logic [ADDR_W-1:0] DC_LOW = ADDR_W'(DC_LINE_W / 8 - 1);

  fsm_e              state;
  logic              req_ready_q, ar_valid_q, r_ready_q, rsp_valid_q;
  logic [1:0]        kind_q;
  logic [7:0]        len_q;
  logic [ADDR_W-1:0] ar_addr_q;
  logic [2:0]        ar_size_q;

  logic [ADDR_W-1:0] plan_addr;
  logic [7:0]        plan_len;
  logic [2:0]        plan_size;
  logic              accept, beat_fire, final_beat;
  logic [7:0]        beat_idx;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign beat_fire = r_valid && r_ready_q;

  lfa_burst_plan #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IC_LINE_W(IC_LINE_W), .DC_LINE_W(DC_LINE_W)
  ) u_plan (
    .kind(req_kind), .addr(req_addr), .size(req_size),
    .plan_addr(plan_addr), .plan_len(plan_len), .plan_size(plan_size)
  );

  lfa_beat_track u_track (
    .clk(clk), .rst(rst), .start(accept), .len(len_q),
    .beat_fire(beat_fire), .beat_last(r_last), .beat_resp(r_resp),
    .beat_idx(beat_idx), .final_beat(final_beat),
    .err_resp(rsp_err_resp), .err_proto(rsp_err_proto)
  );

  lfa_line_buf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk(clk), .rst(rst), .clear(accept), .wr_en(beat_fire),
    .wr_idx(beat_idx), .wr_data(r_data), .line(rsp_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready_q <= 1'b1;
      ar_valid_q  <= 1'b0;
      r_ready_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      kind_q      <= 2'd0;
      len_q       <= 8'd0;
      ar_addr_q   <= '0;
      ar_size_q   <= 3'd0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          state       <= ST_ADDR;
          req_ready_q <= 1'b0;
          ar_valid_q  <= 1'b1;
          ar_addr_q   <= plan_addr;
          len_q       <= plan_len;
          ar_size_q   <= plan_size;
          kind_q      <= req_kind;
        end
        ST_ADDR: if (ar_ready) begin
          state      <= ST_DATA;
          ar_valid_q <= 1'b0;
          r_ready_q  <= 1'b1;
        end
        ST_DATA: if (final_beat) begin
          state       <= ST_RESP;
          r_ready_q   <= 1'b0;
          rsp_valid_q <= 1'b1;
        end
        default: begin
          state       <= ST_IDLE;
          req_ready_q <= 1'b1;
        end
      endcase
    end
  end

  assign req_ready = req_ready_q;
  assign ar_valid  = ar_valid_q;
  assign ar_addr   = ar_addr_q;
  assign ar_len    = len_q;
  assign ar_size   = ar_size_q;
  assign ar_id     = '0;
  assign ar_burst  = BURST_INCR;
  assign ar_cache  = ATTR_NORMAL_NC_NB;
  assign r_ready   = r_ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = kind_q;

  // R6: address request held steady until taken
  a_r6_ar_hold: assert property (@(posedge clk) disable iff (rst)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len) && $stable(ar_size));

  // R6: address and data phases never overlap
  a_r6_phase_excl: assert property (@(posedge clk) disable iff (rst)
    !(ar_valid && r_ready));

  // R2: only three burst lengths ever appear
  a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> (ar_len == 8'd0 || ar_len == IC_LEN || ar_len == DC_LEN));

  // R5: line refills start on a line boundary
  a_r5_line_aligned: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> ((rsp_kind == KIND_ILINE) ? ((ar_addr & IC_LOW) == '0) :
                  (rsp_kind == KIND_DLINE) ? ((ar_addr & DC_LOW) == '0) : 1'b1));

  // R10: idle means nothing in flight
  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !ar_valid && !r_ready && !rsp_valid);

  // R10: completion is a single-cycle pulse followed by readiness
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid && req_ready);

  // R11: sideband is taken only as an input assumption, known when data is valid
  a_r11_user_known: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> !$isunknown(r_user));
endmodule

// File: tb/sim_line_fetch_axi.sv
`timescale 1ns/1ps
module sim_line_fetch_axi;
  localparam int ADDR_W = 32, DATA_W = 64, ID_W = 4, USER_W = 2;
  localparam int IC_LINE_W = 256, DC_LINE_W = 512, LINE_W = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [2:0] req_size = 0;
  logic ar_valid, ar_ready = 0;
  logic [ID_W-1:0] ar_id;
  logic [ADDR_W-1:0] ar_addr;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic [3:0] ar_cache;
  logic r_valid = 0, r_ready, r_last = 0;
  logic [DATA_W-1:0] r_data = 0;
  logic [1:0] r_resp = 0;
  logic [USER_W-1:0] r_user = 0;
  logic rsp_valid, rsp_err_resp, rsp_err_proto;
  logic [1:0] rsp_kind;
  logic [LINE_W-1:0] rsp_line;

  int checks = 0, fails = 0, cycles = 0, seed = 1;

  always #4 clk = ~clk;

  line_fetch_axi #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .USER_W(USER_W),
    .IC_LINE_W(IC_LINE_W), .DC_LINE_W(DC_LINE_W)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst), .ar_cache(ar_cache),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .r_last(r_last), .r_user(r_user), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_line(rsp_line), .rsp_err_resp(rsp_err_resp), .rsp_err_proto(rsp_err_proto)
  );

  task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      finish_run();
    end
  end

  // every-clock monitor of the fixed attributes (R3)
  always @(negedge clk) begin
    if (!rst && ar_valid)
      chk(ar_cache == 4'b0010 && ar_burst == 2'b01 && ar_id == '0, "R3 attributes",
          LINE_W'({ar_id, ar_cache, ar_burst}), LINE_W'({4'h0, 4'b0010, 2'b01}));
  end

  function automatic logic [DATA_W-1:0] pat(input int s, input int b);
    return {32'(s) ^ 32'h5A00_0000, 32'(b) ^ 32'hC0DE_0000};
  endfunction

  // last_mode: 0 marker on the expected beat, 1 early marker at beat last_at, 2 no marker
  task automatic run_read(input logic [1:0] kind, input logic [31:0] addr,
                          input logic [2:0] size, input int ar_wait, input int gap,
                          input int err_beat, input int last_mode, input int last_at);
    int exp_len, nb;
    logic [31:0] exp_addr;
    logic [2:0] exp_size;
    logic [LINE_W-1:0] exp_line;
    bit exp_err, exp_proto;
    seed++;
    case (kind)
      2'd1: begin exp_len = IC_LINE_W/DATA_W - 1; exp_addr = addr & ~32'h1F; exp_size = 3; end
      2'd2: begin exp_len = DC_LINE_W/DATA_W - 1; exp_addr = addr & ~32'h3F; exp_size = 3; end
      default: begin exp_len = 0; exp_addr = addr; exp_size = (size > 3) ? 3'd3 : size; end
    endcase
    nb = (last_mode == 1) ? last_at + 1 : exp_len + 1;
    exp_proto = (last_mode != 0);
    exp_err = (err_beat >= 0) && (err_beat < nb);
    exp_line = '0;
    for (int b = 0; b < nb; b++) exp_line[b*DATA_W +: DATA_W] = pat(seed, b);

    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", LINE_W'(req_ready), 1);
    req_valid = 1; req_kind = kind; req_addr = addr; req_size = size;
    @(negedge clk);
    req_valid = 0;
    chk(ar_valid == 1'b1, "R6 ar_valid after accept", LINE_W'(ar_valid), 1);
    chk(ar_len == 8'(exp_len), "R2 ar_len", LINE_W'(ar_len), LINE_W'(exp_len));
    chk(ar_size == exp_size, "R4 ar_size", LINE_W'(ar_size), LINE_W'(exp_size));
    chk(ar_addr == exp_addr, "R5 ar_addr", LINE_W'(ar_addr), LINE_W'(exp_addr));
    chk(req_ready == 1'b0, "R10 busy after accept", LINE_W'(req_ready), 0);
    for (int w = 0; w < ar_wait; w++) begin
      @(negedge clk);
      chk(ar_valid && ar_addr == exp_addr && ar_len == 8'(exp_len), "R6 ar held",
          LINE_W'(ar_addr), LINE_W'(exp_addr));
    end
    ar_ready = 1;
    @(negedge clk);
    ar_ready = 0;
    chk(!ar_valid && r_ready, "R6 data phase open", LINE_W'({ar_valid, r_ready}), 1);
    for (int b = 0; b < nb; b++) begin
      if (gap > 0) begin
        r_valid = 0;
        repeat (gap) @(negedge clk);
      end
      chk(r_ready == 1'b1, "R6 r_ready during burst", LINE_W'(r_ready), 1);
      r_valid = 1;
      r_data = pat(seed, b);
      r_resp = (b == err_beat) ? 2'b10 : 2'b00;
      r_user = USER_W'($urandom);
      case (last_mode)
        0: r_last = (b == exp_len);
        1: r_last = (b == last_at);
        default: r_last = 1'b0;
      endcase
      @(negedge clk);
    end
    r_valid = 0; r_last = 0; r_resp = 0;
    chk(rsp_valid == 1'b1, "R10 completion pulse", LINE_W'(rsp_valid), 1);
    chk(!r_ready, "R6 r_ready dropped", LINE_W'(r_ready), 0);
    chk(rsp_line == exp_line, "R7 R11 line contents", rsp_line, exp_line);
    chk(rsp_err_resp == exp_err, "R9 response error flag", LINE_W'(rsp_err_resp), LINE_W'(exp_err));
    chk(rsp_err_proto == exp_proto, "R8 last-marker error flag", LINE_W'(rsp_err_proto), LINE_W'(exp_proto));
    chk(rsp_kind == kind, "R2 rsp_kind", LINE_W'(rsp_kind), LINE_W'(kind));
    chk(req_ready == 1'b0, "R10 busy during pulse", LINE_W'(req_ready), 0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 pulse ends, ready again",
        LINE_W'({rsp_valid, req_ready}), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    chk(req_ready == 1'b1, "R1 reset req_ready", LINE_W'(req_ready), 1);
    chk(!ar_valid && !r_ready && !rsp_valid, "R1 reset outputs idle",
        LINE_W'({ar_valid, r_ready, rsp_valid}), 0);
    run_read(2'd1, 32'h0000_1234, 3'd3, 0, 0, -1, 0, 0);   // instruction line
    run_read(2'd2, 32'h8000_0F7C, 3'd3, 2, 1, -1, 0, 0);   // data line with waits
    run_read(2'd0, 32'h0000_2008, 3'd3, 1, 0, -1, 0, 0);   // word load, full bus
    run_read(2'd0, 32'h0000_2006, 3'd1, 0, 2, -1, 0, 0);   // word load, halfword
    run_read(2'd0, 32'h0000_2000, 3'd6, 0, 0, -1, 0, 0);   // R4 size clamp
    run_read(2'd3, 32'h0000_3010, 3'd2, 0, 0, -1, 0, 0);   // R2 kind 3 as word
    run_read(2'd2, 32'h0000_0040, 3'd3, 0, 0, 5, 0, 0);    // R9 error on beat 5
    run_read(2'd2, 32'h0000_0040, 3'd3, 0, 0, -1, 0, 0);   // R9 flag cleared
    run_read(2'd1, 32'h0000_1200, 3'd3, 0, 0, -1, 1, 1);   // R8 early marker, R7 zero tail
    run_read(2'd1, 32'h0000_1200, 3'd3, 1, 1, -1, 2, 0);   // R8 missing marker
    run_read(2'd1, 32'h0000_1234, 3'd3, 0, 1, -1, 0, 0);   // R11 repeat, other sideband
    run_read(2'd0, 32'h0000_5000, 3'd3, 0, 0, 0, 0, 0);    // R9 error on a single beat
    finish_run();
  end
endmodule